// File: doc/BRIEF.md
# Sequential Shift-Add Multiplier (Most Significant Bit First)

This block multiplies two unsigned operands over many clock cycles, using one adder and one register for the running sum. A single-cycle `start` pulse is sampled while the block is idle. The block then captures both operands and clears its running sum and its step counter. It walks the multiplier from its top bit down. For each bit it advances the step counter and tests the bit. When the bit is set, it adds the multiplicand into the sum. When the step counter has not yet reached the operand width, it shifts the sum and the multiplier left together. The shift is skipped on the last step, so the sum already holds the full product. The result is copied to `z` and `done` is raised.

The block has two parts. A datapath holds the multiplicand, multiplier, accumulator, step counter and result registers. A one-hot controller of seven states drives the datapath through eight single-purpose control lines and one strobe that loads the result. The controller visits one state to load, and then repeats test, optional add, end check and shift. A user holds operands steady for two edges after `start`, then waits for `done` to rise again.

Top module: `shift_add_mult`

## Requirements
- R1: While `rst_n` is low and after it is released, `done` is 1 and `z` is 0.
- R2: While idle with `start` low, `done` stays 1 and `z` keeps its value.
- R3: When `start` is sampled high in the idle state, `done` falls to 0 on the following rising edge. That edge is the one that leaves the load state.
- R4: When `done` rises, `z` equals the unsigned product of `x` and `y`, full width 2W bits.
- R5: `done` rises exactly 3W+1+k rising edges after the edge that accepted `start`, where k is the number of 1 bits in `y`. This is 49+k for W=16.
- R6: A `start` pulse that arrives while an operation is in progress has no effect on the result or the timing.
- R7: `z` changes only on the edge where `done` rises, and holds between completions.
- R8: Operands are captured on the edge that leaves the load state, one edge after `start` is accepted. Later changes to `x` and `y` do not affect the result.
- R9: The controller state register always has exactly one bit set.
- R10: The step counter never exceeds W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request a multiplication; sampled only when idle |
| x | input | W | Multiplicand |
| y | input | W | Multiplier, scanned from its top bit |
| done | output | 1 | High while idle and after completion |
| z | output | 2W | Product, held until the next completion |

## Verification
The assertions assume that `start` is sampled only on rising edges. They also assume that the operands are stable from the edge that accepts `start` through the next edge, because the capture edge lies one cycle after acceptance. The stimulus drives every input on the falling clock edge. It keeps `x` and `y` unchanged until the capture edge has passed, and only then scrambles them. Extra `start` pulses are placed deliberately inside busy windows. `start` is also held high across a completion, which exercises back-to-back requests.

// File: rtl/mult_pkg.sv
package mult_pkg;

    // One-hot controller states: one flop per state
    typedef enum logic [6:0] {
        ST_IDLE  = 7'b0000001,
        ST_LOAD  = 7'b0000010,
        ST_TEST  = 7'b0000100,
        ST_ADD   = 7'b0001000,
        ST_CHK   = 7'b0010000,
        ST_SHIFT = 7'b0100000,
        ST_OUT   = 7'b1000000
    } state_t;

    // Discrete datapath control lines
    typedef struct packed {
        logic ld_a;    // capture multiplicand
        logic ld_b;    // capture multiplier
        logic clr_m;   // clear accumulator
        logic clr_i;   // clear step counter
        logic inc_i;   // advance step counter
        logic add_m;   // accumulator += multiplicand
        logic shl_m;   // accumulator <<= 1
        logic shl_b;   // multiplier <<= 1
    } ctl_t;

endpackage

// File: rtl/mult_ctrl.sv
module mult_ctrl
    import mult_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   start,
    input  logic   b_msb,
    input  logic   cnt_full,
    output ctl_t   ctl,
    output logic   z_ld,
    output logic   done,
    output state_t state
);

    typedef struct packed {
        state_t st;
        logic   done;
    } fsm_t;

    fsm_t fsm_d, fsm_q;

    always_comb begin
        fsm_d = fsm_q;
        ctl   = '0;
        z_ld  = 1'b0;
        unique case (fsm_q.st)
            ST_IDLE: begin
                if (start) fsm_d.st = ST_LOAD;
            end
            ST_LOAD: begin
                ctl.ld_a   = 1'b1;
                ctl.ld_b   = 1'b1;
                ctl.clr_m  = 1'b1;
                ctl.clr_i  = 1'b1;
                fsm_d.done = 1'b0;
                fsm_d.st   = ST_TEST;
            end
            ST_TEST: begin
                ctl.inc_i = 1'b1;
                fsm_d.st  = b_msb ? ST_ADD : ST_CHK;
            end
            ST_ADD: begin
                ctl.add_m = 1'b1;
                fsm_d.st  = ST_CHK;
            end
            ST_CHK: begin
                fsm_d.st = cnt_full ? ST_OUT : ST_SHIFT;
            end
            ST_SHIFT: begin
                ctl.shl_m = 1'b1;
                ctl.shl_b = 1'b1;
                fsm_d.st  = ST_TEST;
            end
            ST_OUT: begin
                z_ld       = 1'b1;
                fsm_d.done = 1'b1;
                fsm_d.st   = ST_IDLE;
            end
            default: begin
                fsm_d.st   = ST_IDLE;
                fsm_d.done = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fsm_q.st   <= ST_IDLE;
            fsm_q.done <= 1'b1;
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign done  = fsm_q.done;
    assign state = fsm_q.st;

endmodule

// File: rtl/mult_dpath.sv
module mult_dpath
    import mult_pkg::*;
#(
    parameter int W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [W-1:0]            x,
    input  logic [W-1:0]            y,
    input  ctl_t                    ctl,
    input  logic                    z_ld,
    output logic                    b_msb,
    output logic                    cnt_full,
    output logic [2*W-1:0]          z,
    output logic [$clog2(W):0]      cnt
);

    localparam int PW = 2 * W;
    localparam int CW = $clog2(W) + 1;

    typedef struct packed {
        logic [W-1:0]  a;
        logic [W-1:0]  b;
        logic [PW-1:0] m;
        logic [CW-1:0] i;
        logic [PW-1:0] z;
    } dp_t;

    dp_t dp_d, dp_q;

    always_comb begin
        dp_d = dp_q;
        if (ctl.ld_a) dp_d.a = x;
        if (ctl.ld_b)
            dp_d.b = y;
        else if (ctl.shl_b)
            dp_d.b = {dp_q.b[W-2:0], 1'b0};
        if (ctl.clr_m)
            dp_d.m = '0;
        else if (ctl.add_m)
            dp_d.m = dp_q.m + PW'(dp_q.a);
        else if (ctl.shl_m)
            dp_d.m = {dp_q.m[PW-2:0], 1'b0};
        if (ctl.clr_i)
            dp_d.i = '0;
        else if (ctl.inc_i)
            dp_d.i = dp_q.i + 1'b1;
        if (z_ld) dp_d.z = dp_q.m;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dp_q <= '0;
        else        dp_q <= dp_d;
    end

    assign b_msb    = dp_q.b[W-1];
    assign cnt_full = (dp_q.i == CW'(W));
    assign z        = dp_q.z;
    assign cnt      = dp_q.i;

endmodule

// File: rtl/shift_add_mult.sv
module shift_add_mult
    import mult_pkg::*;
#(
    parameter int W = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [W-1:0]   x,
    input  logic [W-1:0]   y,
    output logic           done,
    output logic [2*W-1:0] z
);

    localparam int CW = $clog2(W) + 1;

    ctl_t          ctl;
    logic          z_ld;
    logic          b_msb;
    logic          cnt_full;
    state_t        state_q;
    logic [CW-1:0] cnt_q;

    mult_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .b_msb    (b_msb),
        .cnt_full (cnt_full),
        .ctl      (ctl),
        .z_ld     (z_ld),
        .done     (done),
        .state    (state_q)
    );

    mult_dpath #(.W(W)) u_dpath (
        .clk      (clk),
        .rst_n    (rst_n),
        .x        (x),
        .y        (y),
        .ctl      (ctl),
        .z_ld     (z_ld),
        .b_msb    (b_msb),
        .cnt_full (cnt_full),
        .z        (z),
        .cnt      (cnt_q)
    );

endmodule

// File: rtl/mult_chk.sv
module mult_chk
    import mult_pkg::*;
#(
    parameter int W = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                done,
    input logic [2*W-1:0]      z,
    input logic [6:0]          state,
    input logic [$clog2(W):0]  cnt
);

    localparam int CW = $clog2(W) + 1;

    a_r9_state_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(state));

    a_r10_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(W));

    a_r2_idle_done: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> done);

    a_r3_load_clears_done: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOAD) |=> !done);

    a_r6_busy_no_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |=> (state != ST_LOAD));

    a_r7_z_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(done) |-> $stable(z));

endmodule

bind shift_add_mult mult_chk #(.W(W)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .done  (done),
    .z     (z),
    .state (state_q),
    .cnt   (cnt_q)
);

// File: tb/shift_add_mult_bench.sv
module shift_add_mult_bench;

    localparam int W = 16;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start = 1'b0;
    logic [W-1:0]   x = '0;
    logic [W-1:0]   y = '0;
    logic           done;
    logic [2*W-1:0] z;

    int vectors = 0;
    int errors  = 0;

    // Behavioural reference state
    bit             m_busy = 0;
    int             m_cnt = 0;
    int             m_tgt = 0;
    logic [2*W-1:0] m_prod = '0;
    logic           m_done = 1'b1;
    logic [2*W-1:0] m_z = '0;

    always #10 clk = ~clk;

    shift_add_mult #(.W(W)) u_shift_add_mult (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .x     (x),
        .y     (y),
        .done  (done),
        .z     (z)
    );

    // Reference: edge count from start acceptance to completion is 3W+1+ones(y)
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_busy = 0;
            m_done = 1'b1;
            m_z    = '0;
        end else if (!m_busy) begin
            if (start) begin
                m_busy = 1;
                m_cnt  = 0;
                m_tgt  = 3 * W + 1 + $countones(y);
                m_prod = (2*W)'(x) * (2*W)'(y);
            end
        end else begin
            m_cnt = m_cnt + 1;
            if (m_cnt == 1) m_done = 1'b0;
            if (m_cnt == m_tgt) begin
                m_done = 1'b1;
                m_z    = m_prod;
                m_busy = 0;
            end
        end
    end

    // Compare every cycle, away from the active edge
    always @(negedge clk) begin
        string tag_d, tag_z;
        if (!rst_n) begin
            tag_d = "R1"; tag_z = "R1";
        end else if (m_busy) begin
            tag_d = "R3 R5 R6"; tag_z = "R6 R7 R8";
        end else begin
            tag_d = "R2 R5"; tag_z = "R4 R7 R8";
        end
        vectors++;
        if (done !== m_done) begin
            errors++;
            $display("FAIL %s done: actual %0b expected %0b at %0t", tag_d, done, m_done, $time);
        end
        vectors++;
        if (z !== m_z) begin
            errors++;
            $display("FAIL %s z: actual %h expected %h at %0t", tag_z, z, m_z, $time);
        end
    end

    task automatic wait_idle();
        @(negedge clk);
        while (m_busy) @(negedge clk);
    endtask

    // One operation; operands scrambled after the capture edge (R8)
    task automatic run_op(input logic [W-1:0] xv, input logic [W-1:0] yv, input bit extra_start);
        @(negedge clk);
        x = xv; y = yv; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        x = W'($urandom); y = W'($urandom);
        if (extra_start) begin
            // R6: stray request while busy
            repeat (7) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        wait_idle();
        repeat (3) @(negedge clk); // R2, R7: idle hold
    endtask

    task automatic run_all();
        repeat (3) @(negedge clk);   // R1 during reset
        rst_n = 1'b1;
        repeat (4) @(negedge clk);   // R1, R2 after release
        run_op(16'h0000, 16'h0000, 0);
        run_op(16'h0000, 16'hFFFF, 0);
        run_op(16'hFFFF, 16'h0000, 0);
        run_op(16'h0001, 16'h0001, 0);
        run_op(16'hFFFF, 16'hFFFF, 0); // R4, R5 widest latency
        run_op(16'h0001, 16'hFFFF, 1);
        run_op(16'h8000, 16'h8000, 0);
        run_op(16'h1234, 16'h0001, 1);
        for (int n = 0; n < 24; n++)
            run_op(W'($urandom), W'($urandom), n[0]);
        // Back-to-back: start held high across a completion
        @(negedge clk);
        x = 16'hBEEF; y = 16'h00F1; start = 1'b1;
        @(negedge clk);
        while (m_busy) @(negedge clk);
        @(negedge clk);
        start = 1'b0;
        wait_idle();
        repeat (3) @(negedge clk);
        // R9, R10: held by the bound checker throughout every operation above
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                errors++;
                $display("FAIL watchdog: run did not complete");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule